// File: doc/BRIEF.md
# Sample FIFO with Block-Count Interrupt

This block sits between an analog-to-digital converter and a host. Each conversion strobe presents a 16-bit word whose upper bits hold a left-justified 12-bit sample above three marker bits. The block stores the word in a first-in first-out buffer. The host drains the buffer one word per read strobe and watches three status bits that tell it whether data is waiting, whether the buffer is less than half full, and whether there is room left.

A reloading 16-bit block counter counts every stored sample. It is programmed with N−1, and it raises a one-cycle interrupt request each time N samples have been stored. The host can then read a known number of words without polling. The counter can be set to keep running after it fires or to halt acquisition until it is re-armed. A full buffer halts conversion on its own. Any conversion strobe that arrives while the buffer is full is dropped and recorded in a sticky overrun flag.

Top module: `smpbuf_top`

## Requirements
- R1: The depth is a power-of-two parameter (1024 by default; 8192 is also supported). `stat` bit 0 is not-empty, bit 1 is half-empty and bit 2 is not-full, and all three are active high. An empty buffer reads `stat` = 3'b110.
- R2: Words leave in the order they were written. A read strobe on a non-empty buffer presents the oldest word on `rd_word` in the cycle after the strobe's clock edge, and `rd_sample` equals `rd_word[14:3]`.
- R3: Half-empty (bit 1) is 1 while occupancy is below DEPTH/2 and 0 once occupancy reaches DEPTH/2.
- R4: With DEPTH words stored, not-full (bit 2) reads 0 and `conv_halt` is 1. A strobe that arrives while the buffer is full is not stored.
- R5: A conversion strobe while the buffer is full sets `ovr_flag`. The flag stays set until a pulse on `ovr_clr`.
- R6: A pulse on `fifo_clr` empties the buffer, so `stat` reads 3'b110 afterwards. A conversion strobe in the same cycle is discarded.
- R7: A read strobe on an empty buffer leaves `rd_word` at the last word read and moves no pointer, so a later write is read back normally.
- R8: A pulse on `blk_load` loads `blk_val` = N−1. `blk_irq` then pulses for one cycle after every N-th stored sample, and the counter reloads by itself.
- R9: With `blk_stop_en` = 1, the expiring count also raises `conv_halt`. Strobes are ignored, without overrun, until the next `blk_load` re-arms acquisition.
- R10: After reset, `rd_word` is 0 and `blk_irq`, `conv_halt` and `ovr_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_stb | input | 1 | Conversion strobe: store `conv_word` |
| conv_word | input | 16 | Converted word, sample in [14:3] |
| rd_stb | input | 1 | Host read strobe |
| rd_word | output | 16 | Last word read |
| rd_sample | output | 12 | Sample field of `rd_word` |
| fifo_clr | input | 1 | Empty the buffer |
| stat | output | 3 | {not-full, half-empty, not-empty} |
| blk_load | input | 1 | Load block count and re-arm |
| blk_val | input | 16 | Block size minus one |
| blk_stop_en | input | 1 | Halt acquisition when the count expires |
| blk_irq | output | 1 | Block-complete interrupt pulse |
| conv_halt | output | 1 | Conversion inhibited (full or stopped) |
| ovr_flag | output | 1 | Sticky overrun |
| ovr_clr | input | 1 | Clear the overrun flag |

## Verification
A table-driven sequence mixes writes, reads, reads of an empty buffer and a clear. It separates the ordering of stored words from the hold-on-empty behaviour, and it shows the status bits changing at each step. A full fill-and-drain to the default depth tests the half-empty edge at exactly DEPTH/2 and the full edge, and it shows that a rejected word never overwrites stored data. Two block-counter runs, one free-running with N=4 and one stopping with N=2, separate the reload behaviour from the halt behaviour. The stopping run also shows that strobes ignored while stopped differ from strobes lost on a full buffer, because only the latter set the overrun flag.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
    // Host-visible status: bit 2 not-full, bit 1 half-empty, bit 0 not-empty
    typedef struct packed {
        logic not_full;
        logic half_empty;
        logic not_empty;
    } smp_stat_t;
endpackage

// File: rtl/smpbuf_ptrs.sv
module smpbuf_ptrs #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_req,
    input  logic          clr,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_fire,
    output logic          full,
    output logic          empty,
    output logic          half_empty
);
    localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t        st_q, st_d;
    logic [AW:0] occ;

    assign occ        = st_q.wp - st_q.rp;
    assign empty      = (st_q.wp == st_q.rp);
    assign full       = (st_q.wp[AW] != st_q.rp[AW]) && (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
    assign half_empty = (occ < HALF);
    assign wr_addr    = st_q.wp[AW-1:0];
    assign rd_addr    = st_q.rp[AW-1:0];
    assign rd_fire    = rd_req && !empty && !clr;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wp = '0;
            st_d.rp = '0;
        end else begin
            if (wr_en)   st_d.wp = st_q.wp + 1'b1;
            if (rd_fire) st_d.rp = st_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/smpbuf_mem.sv
module smpbuf_mem #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] store [DEPTH];
    logic [W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Output register holds its value when no read fires
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= store[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/smpbuf_blkcnt.sv
module smpbuf_blkcnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          stop_en,
    input  logic          tick,
    output logic          irq,
    output logic          stopped
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
        logic          irq;
        logic          stp;
    } cnt_t;

    cnt_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
            st_d.rld = load_val;
            st_d.stp = 1'b0;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.irq = 1'b1;
                st_d.cnt = st_q.rld;
                if (stop_en) st_d.stp = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.rld <= '1;
            st_q.irq <= 1'b0;
            st_q.stp <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign stopped = st_q.stp;
endmodule

// File: rtl/smpbuf_top.sv
module smpbuf_top #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    parameter int CW    = 16,
    parameter int SLSB  = 3,
    parameter int SW    = 12,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_stb,
    input  logic [W-1:0]  conv_word,
    input  logic          rd_stb,
    output logic [W-1:0]  rd_word,
    output logic [SW-1:0] rd_sample,
    input  logic          fifo_clr,
    output logic [2:0]    stat,
    input  logic          blk_load,
    input  logic [CW-1:0] blk_val,
    input  logic          blk_stop_en,
    output logic          blk_irq,
    output logic          conv_halt,
    output logic          ovr_flag,
    input  logic          ovr_clr
);
    import smpbuf_pkg::*;

    logic          full, empty, half_e, rd_fire, wr_en, stopped;
    logic [AW-1:0] wr_addr, rd_addr;
    logic          ovr_q, ovr_d;
    smp_stat_t     st;

    assign wr_en = conv_stb && !full && !stopped && !fifo_clr;

    smpbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_stb), .clr(fifo_clr),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_fire(rd_fire),
        .full(full), .empty(empty), .half_empty(half_e)
    );

    smpbuf_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(conv_word),
        .rd_en(rd_fire), .rd_addr(rd_addr), .rd_data(rd_word)
    );

    smpbuf_blkcnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(blk_load), .load_val(blk_val),
        .stop_en(blk_stop_en), .tick(wr_en), .irq(blk_irq), .stopped(stopped)
    );

    // Sticky overrun; a new overrun wins over a simultaneous clear
    always_comb begin
        ovr_d = ovr_q;
        if (ovr_clr)         ovr_d = 1'b0;
        if (conv_stb && full) ovr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    assign st.not_full   = !full;
    assign st.half_empty = half_e;
    assign st.not_empty  = !empty;
    assign stat          = st;
    assign ovr_flag      = ovr_q;
    assign conv_halt     = full || stopped;
    assign rd_sample     = rd_word[SLSB +: SW];
endmodule

// File: rtl/smpbuf_chk.sv
module smpbuf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_stb,
    input logic        rd_stb,
    input logic [15:0] rd_word,
    input logic        fifo_clr,
    input logic [2:0]  stat,
    input logic        blk_stop_en,
    input logic        blk_irq,
    input logic        conv_halt,
    input logic        ovr_flag,
    input logic        ovr_clr
);
    a_r1_empty_implies_room: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[0] |-> (stat[2] && stat[1]));

    a_r3_full_not_half: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[2] |-> !stat[1]);

    a_r4_halt_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[2] |-> conv_halt);

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_stb && !stat[2]) |=> ovr_flag);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (stat == 3'b110));

    a_r7_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !stat[0]) |=> $stable(rd_word));

    a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_irq && $past(blk_stop_en)) |-> conv_halt);
endmodule

bind smpbuf_top smpbuf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .conv_stb(conv_stb), .rd_stb(rd_stb), .rd_word(rd_word),
    .fifo_clr(fifo_clr), .stat(stat), .blk_stop_en(blk_stop_en), .blk_irq(blk_irq),
    .conv_halt(conv_halt), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
);

// File: tb/sim_smpbuf_top.sv
`timescale 1ns/1ps
module sim_smpbuf_top;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_stb = 1'b0;
    logic [15:0] conv_word = '0;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_word;
    logic [11:0] rd_sample;
    logic        fifo_clr = 1'b0;
    logic [2:0]  stat;
    logic        blk_load = 1'b0;
    logic [15:0] blk_val = '0;
    logic        blk_stop_en = 1'b0;
    logic        blk_irq;
    logic        conv_halt;
    logic        ovr_flag;
    logic        ovr_clr = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    smpbuf_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_stb(conv_stb), .conv_word(conv_word),
        .rd_stb(rd_stb), .rd_word(rd_word), .rd_sample(rd_sample), .fifo_clr(fifo_clr),
        .stat(stat), .blk_load(blk_load), .blk_val(blk_val), .blk_stop_en(blk_stop_en),
        .blk_irq(blk_irq), .conv_halt(conv_halt), .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    // Vector: {op[1:0], data[15:0], exp_stat[2:0], exp_rd[15:0]}; op 0 write, 1 read, 2 clear
    localparam int NV = 8;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 16'h1238, 3'b111, 16'h0000},
        {2'd0, 16'h2460, 3'b111, 16'h0000},
        {2'd1, 16'h0000, 3'b111, 16'h1238},
        {2'd1, 16'h0000, 3'b110, 16'h2460},
        {2'd1, 16'h0000, 3'b110, 16'h2460},
        {2'd0, 16'h7FF8, 3'b111, 16'h2460},
        {2'd2, 16'h0000, 3'b110, 16'h2460},
        {2'd1, 16'h0000, 3'b110, 16'h2460}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive for one clock edge; return at the next falling edge with outputs settled
    task automatic wr(input logic [15:0] w);
        conv_stb = 1'b1; conv_word = w;
        @(negedge clk);
        conv_stb = 1'b0;
    endtask

    task automatic rd();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic clr();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic load(input logic [15:0] v, input logic stop);
        blk_val = v; blk_stop_en = stop; blk_load = 1'b1;
        @(negedge clk);
        blk_load = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R1 reset state
        chk("R10 rd_word", rd_word, 0);
        chk("R10 irq/halt/ovr", {blk_irq, conv_halt, ovr_flag}, 0);
        chk("R1 empty status", stat, 3'b110);

        // Table walk: R2 ordering, R7 empty read, R6 clear
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            op = VEC[i][36:35];
            if (op == 2'd0)      wr(VEC[i][34:19]);
            else if (op == 2'd1) rd();
            else                 clr();
            chk($sformatf("R2/R6/R7 vec%0d stat", i), stat, VEC[i][18:16]);
            chk($sformatf("R2/R7 vec%0d rd_word", i), rd_word, VEC[i][15:0]);
        end

        // R7: pointers untouched by empty reads, next write reads back
        wr(16'h0AB8);
        rd();
        chk("R7 write after empty reads", rd_word, 16'h0AB8);
        chk("R2 sample field", rd_sample, 12'h157);

        // R6: clear wins over a simultaneous write
        conv_stb = 1'b1; conv_word = 16'h1110; fifo_clr = 1'b1;
        @(negedge clk);
        conv_stb = 1'b0; fifo_clr = 1'b0;
        chk("R6 clear drops write", stat, 3'b110);

        // R8: N = 4, free running
        load(16'd3, 1'b0);
        for (int k = 0; k < 8; k++) begin
            wr(16'(k << 3));
            chk($sformatf("R8 irq after write %0d", k), blk_irq, (k % 4) == 3);
        end
        chk("R8 no halt in run mode", conv_halt, 1'b0);
        clr();

        // R9: N = 2, stop mode
        load(16'd1, 1'b1);
        wr(16'h0008);
        chk("R9 first write no halt", {blk_irq, conv_halt}, 2'b00);
        wr(16'h0010);
        chk("R9 expiry halts", {blk_irq, conv_halt}, 2'b11);
        wr(16'h0018);
        chk("R9 ignored strobe no overrun", ovr_flag, 1'b0);
        rd(); rd(); rd();
        chk("R9 ignored strobe not stored", rd_word, 16'h0010);
        chk("R9 buffer drained", stat, 3'b110);
        load(16'hFFFF, 1'b0);
        chk("R9 re-arm clears halt", conv_halt, 1'b0);

        // R3/R4/R5: fill to depth
        for (int i = 0; i < DEPTH; i++) begin
            wr(16'(i << 3));
            if (i == DEPTH/2 - 2) chk("R3 below half", stat[1], 1'b1);
            if (i == DEPTH/2 - 1) chk("R3 at half", stat[1], 1'b0);
            if (i == DEPTH - 2)   chk("R4 one slot left", stat[2], 1'b1);
        end
        chk("R4 full status", stat, 3'b001);
        chk("R4 halt on full", conv_halt, 1'b1);
        chk("R5 no overrun yet", ovr_flag, 1'b0);
        wr(16'h7FF8);
        chk("R5 overrun set", ovr_flag, 1'b1);
        rd();
        chk("R4 oldest word intact", rd_word, 16'h0000);
        chk("R4 halt released", conv_halt, 1'b0);
        chk("R5 overrun sticky", ovr_flag, 1'b1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R5 overrun cleared", ovr_flag, 1'b0);
        for (int i = 1; i < DEPTH; i++) rd();
        chk("R4 rejected word not stored", rd_word, 16'((DEPTH - 1) << 3));
        chk("R2 last sample", rd_sample, 12'(DEPTH - 1));
        chk("R1 drained status", stat, 3'b110);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule